// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a processor core and decides when the program flow must jump to a service routine. It gathers a set of maskable hardware request lines, a wake-up source, a software interrupt and two trap inputs. Each vectored source latches into a pending word. When the core signals that it has just finished an interruptible instruction, the highest-priority pending and enabled source is taken. The block then pulses a branch request with that source's vector address, raises the acknowledge line and shows a 4-bit service code until the core reports a return from interrupt.

The traps are handled separately. A user trap or a debug trap is taken at once, without waiting for an interruptible boundary, and it can preempt a vectored interrupt that is already being serviced. Only one trap can be in service at a time. The user trap drives the acknowledge line and the code; the debug trap leaves both unchanged. Software reads the enable and pending words directly, writes the enable word, and clears pending bits by writing ones.

Top module: `pvic_top`

## Requirements
- R1: On reset, every pending and enable bit is 0, `branch_o` and `iack_o` are 0 and `code_o` is 0.
- R2: A rising edge on a hardware request line sets its pending bit whether or not that source is enabled. A source whose enable bit is 0 is never taken.
- R3: A source that is pending while disabled is taken at the first boundary strobe after its enable bit is written to 1. No new request edge is needed.
- R4: Vectored sources are indexed 0 to HW_IRQS+1, where index HW_IRQS is the wake-up source and index HW_IRQS+1 is the software interrupt. A lower index has higher priority. A vectored interrupt is taken only in a cycle where `ipoint_i` is 1. When it is taken, `branch_o` is 1 for one cycle, `vector_o` = 0x04 + 4*index, and `code_o` = index+1.
- R5: `iack_o` rises with the branch and stays at 1, with `code_o` held, until `rti_i`. While a vectored interrupt is in service, no other vectored interrupt is taken.
- R6: `rti_i` clears only the pending bit of the source being serviced. Other pending sources are then taken one at a time, in priority order.
- R7: When `reg_wr_i`=1 and `reg_sel_i`=1, each 1 in `reg_wdata_i` clears the matching pending bit. When `reg_sel_i`=0, the write loads the enable word from `reg_wdata_i[HW_IRQS:0]`.
- R8: The wake-up source (pending bit HW_IRQS) is the OR of `rxf_a_i` and `rxf_b_i`. A `swi_i` pulse sets pending bit HW_IRQS+1. That bit has no enable bit and is always eligible.
- R9: A rising `utrap_i` is taken at the next edge without any boundary strobe. It outranks a same-cycle interrupt and a same-cycle debug trap, and it can preempt an interrupt in service. It gives vector 0x46, `iack_o`=1 and `code_o`=0xD. After its `rti_i`, the preempted interrupt's acknowledge and code return.
- R10: A rising `dtrap_i` is taken with vector 0x03 and leaves `iack_o` and `code_o` unchanged.
- R11: A trap input that rises while a trap is in service is ignored, even after that service ends. A trap input held high fires only once and re-arms only after it goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | HW_IRQS | Hardware request lines, rising-edge detected |
| rxf_a_i | input | 1 | First input-buffer-full flag for wake-up |
| rxf_b_i | input | 1 | Second input-buffer-full flag for wake-up |
| swi_i | input | 1 | Software interrupt pulse |
| ipoint_i | input | 1 | Core completed an interruptible instruction |
| rti_i | input | 1 | Return-from-interrupt strobe |
| utrap_i | input | 1 | User trap level input |
| dtrap_i | input | 1 | Debug trap level input |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0: enable word, 1: pending clear |
| reg_wdata_i | input | HW_IRQS+2 | Register write data |
| status_o | output | HW_IRQS+2 | Pending word |
| enable_o | output | HW_IRQS+1 | Enable word |
| branch_o | output | 1 | One-cycle branch request |
| vector_o | output | 8 | Branch target address |
| iack_o | output | 1 | Interrupt acknowledge |
| code_o | output | 4 | Service code of the source in service |

## Verification
The bench first checks that a masked edge is held rather than lost. A design that drops it would never branch after the later enable write. It then checks that a source in service blocks later boundary strobes, and that the return clears just one pending bit. A design wrong here would branch twice or lose the lower-priority request. For traps, it preempts an interrupt in service, holds a second trap across the service window, and raises the user trap together with a boundary strobe. These cases expose a design that nests traps, fires again on a held level, lets the debug trap disturb the acknowledge and code, or restores the wrong code after return.

// File: rtl/pvic_pkg.sv
`timescale 1ns/1ps
package pvic_pkg;
    localparam int HW_IRQS_DEF = 4;
    localparam int VEC_W       = 8;
    localparam int CODE_W      = 4;
    localparam int VEC_STEP    = 4;
    localparam logic [VEC_W-1:0]  VEC_BASE   = 8'h04;
    localparam logic [VEC_W-1:0]  UTRAP_VEC  = 8'h46;
    localparam logic [VEC_W-1:0]  DTRAP_VEC  = 8'h03;
    localparam logic [CODE_W-1:0] UTRAP_CODE = 4'hD;
    localparam logic [CODE_W-1:0] IDLE_CODE  = 4'h0;

    typedef enum logic [1:0] {TAKE_NONE, TAKE_IRQ, TAKE_UTRAP, TAKE_DTRAP} take_e;

    function automatic logic [VEC_W-1:0] vec_of(input int idx);
        return VEC_W'(int'(VEC_BASE) + VEC_STEP * idx);
    endfunction

    function automatic logic [CODE_W-1:0] code_of(input int idx);
        return CODE_W'(idx + 1);
    endfunction
endpackage

// File: rtl/pvic_pending.sv
`timescale 1ns/1ps
module pvic_pending #(
    parameter int MASK_N = 5,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MASK_N-1:0] lvl_req,
    input  logic              swi_pulse,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [MASK_N:0]   wr_data,
    input  logic              done_clr,
    input  logic [IDX_W-1:0]  done_idx,
    output logic [MASK_N:0]   status_q,
    output logic [MASK_N-1:0] enable_q,
    output logic [MASK_N:0]   eligible
);
    localparam int SRC_N = MASK_N + 1;

    logic [MASK_N-1:0] lvl_q;
    logic [SRC_N-1:0]  set_v, clr_v;

    always_comb begin
        set_v = {swi_pulse, lvl_req & ~lvl_q};
        clr_v = '0;
        if (wr_en && wr_sel) clr_v = wr_data;
        if (done_clr)        clr_v = clr_v | (SRC_N'(1) << done_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q    <= '0;
            status_q <= '0;
            enable_q <= '0;
        end else begin
            lvl_q    <= lvl_req;
            status_q <= (status_q & ~clr_v) | set_v;
            if (wr_en && !wr_sel) enable_q <= wr_data[MASK_N-1:0];
        end
    end

    assign eligible = status_q & {1'b1, enable_q};
endmodule

// File: rtl/pvic_select.sv
`timescale 1ns/1ps
module pvic_select #(
    parameter int SRC_N = 6,
    parameter int IDX_W = 3
) (
    input  logic [SRC_N-1:0] eligible,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pvic_top.sv
`timescale 1ns/1ps
module pvic_top #(
    parameter int HW_IRQS = pvic_pkg::HW_IRQS_DEF,
    localparam int SRC_N  = HW_IRQS + 2,
    localparam int MASK_N = HW_IRQS + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [HW_IRQS-1:0]         irq_i,
    input  logic                       rxf_a_i,
    input  logic                       rxf_b_i,
    input  logic                       swi_i,
    input  logic                       ipoint_i,
    input  logic                       rti_i,
    input  logic                       utrap_i,
    input  logic                       dtrap_i,
    input  logic                       reg_wr_i,
    input  logic                       reg_sel_i,
    input  logic [SRC_N-1:0]           reg_wdata_i,
    output logic [SRC_N-1:0]           status_o,
    output logic [MASK_N-1:0]          enable_o,
    output logic                       branch_o,
    output logic [pvic_pkg::VEC_W-1:0] vector_o,
    output logic                       iack_o,
    output logic [pvic_pkg::CODE_W-1:0] code_o
);
    import pvic_pkg::*;
    localparam int IDX_W = $clog2(SRC_N);

    logic [SRC_N-1:0] eligible;
    logic             hit;
    logic [IDX_W-1:0] sel_idx, cur_idx_q;
    logic             busy_q, trap_act_q, utrap_svc_q, ut_q, dt_q;
    logic             rti_trap, rti_irq;
    take_e            take;

    pvic_pending #(.MASK_N(MASK_N), .IDX_W(IDX_W)) u_pend (
        .clk(clk), .rst(rst),
        .lvl_req({rxf_a_i | rxf_b_i, irq_i}),
        .swi_pulse(swi_i),
        .wr_en(reg_wr_i), .wr_sel(reg_sel_i), .wr_data(reg_wdata_i),
        .done_clr(rti_irq), .done_idx(cur_idx_q),
        .status_q(status_o), .enable_q(enable_o), .eligible(eligible)
    );

    pvic_select #(.SRC_N(SRC_N), .IDX_W(IDX_W)) u_sel (
        .eligible(eligible), .hit(hit), .idx(sel_idx)
    );

    assign rti_trap = rti_i && trap_act_q;
    assign rti_irq  = rti_i && !trap_act_q && busy_q;

    always_comb begin
        take = TAKE_NONE;
        if (!trap_act_q && utrap_i && !ut_q)      take = TAKE_UTRAP;
        else if (!trap_act_q && dtrap_i && !dt_q) take = TAKE_DTRAP;
        else if (!trap_act_q && !busy_q && ipoint_i && hit) take = TAKE_IRQ;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ut_q        <= 1'b0;
            dt_q        <= 1'b0;
            busy_q      <= 1'b0;
            cur_idx_q   <= '0;
            trap_act_q  <= 1'b0;
            utrap_svc_q <= 1'b0;
            branch_o    <= 1'b0;
            vector_o    <= '0;
        end else begin
            ut_q     <= utrap_i;
            dt_q     <= dtrap_i;
            branch_o <= (take != TAKE_NONE);
            if (rti_trap) begin
                trap_act_q  <= 1'b0;
                utrap_svc_q <= 1'b0;
            end
            if (rti_irq) busy_q <= 1'b0;
            case (take)
                TAKE_UTRAP: begin
                    trap_act_q  <= 1'b1;
                    utrap_svc_q <= 1'b1;
                    vector_o    <= UTRAP_VEC;
                end
                TAKE_DTRAP: begin
                    trap_act_q <= 1'b1;
                    vector_o   <= DTRAP_VEC;
                end
                TAKE_IRQ: begin
                    busy_q    <= 1'b1;
                    cur_idx_q <= sel_idx;
                    vector_o  <= vec_of(int'(sel_idx));
                end
                default: ;
            endcase
        end
    end

    assign iack_o = busy_q | utrap_svc_q;
    assign code_o = utrap_svc_q ? UTRAP_CODE :
                    busy_q      ? code_of(int'(cur_idx_q)) : IDLE_CODE;
endmodule

// File: rtl/pvic_chk.sv
`timescale 1ns/1ps
module pvic_chk #(
    parameter int VEC_W  = 8,
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              ipoint_i,
    input logic              rti_i,
    input logic              branch_o,
    input logic [VEC_W-1:0]  vector_o,
    input logic              iack_o,
    input logic [CODE_W-1:0] code_o,
    input logic              trap_act
);
    // R4
    irq_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (branch_o && vector_o != 8'h46 && vector_o != 8'h03) |-> $past(ipoint_i));

    // R5
    iack_drop_on_rti_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(iack_o) |-> $past(rti_i));

    // R5
    iack_code_pair_chk: assert property (@(posedge clk) disable iff (rst)
        iack_o == (code_o != '0));

    // R9
    utrap_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (branch_o && vector_o == 8'h46) |-> (iack_o && code_o == 4'hD));

    // R11
    no_trap_nest_chk: assert property (@(posedge clk) disable iff (rst)
        (branch_o && (vector_o == 8'h46 || vector_o == 8'h03)) |-> !$past(trap_act));

    // R10
    dtrap_code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (branch_o && vector_o == 8'h03 && !$past(rti_i)) |-> $stable(code_o));
endmodule

bind pvic_top pvic_chk #(.VEC_W(pvic_pkg::VEC_W), .CODE_W(pvic_pkg::CODE_W)) u_chk (
    .clk(clk), .rst(rst), .ipoint_i(ipoint_i), .rti_i(rti_i),
    .branch_o(branch_o), .vector_o(vector_o), .iack_o(iack_o),
    .code_o(code_o), .trap_act(trap_act_q)
);

// File: tb/pvic_top_test.sv
`timescale 1ns/1ps
module pvic_top_test;
    localparam int NHW = 4;
    localparam int NS  = NHW + 2;
    localparam int NM  = NHW + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NHW-1:0] irq_i = '0;
    logic rxf_a_i = 0, rxf_b_i = 0, swi_i = 0, ipoint_i = 0, rti_i = 0;
    logic utrap_i = 0, dtrap_i = 0, reg_wr_i = 0, reg_sel_i = 0;
    logic [NS-1:0] reg_wdata_i = '0;
    logic [NS-1:0] status_o;
    logic [NM-1:0] enable_o;
    logic branch_o, iack_o;
    logic [7:0] vector_o;
    logic [3:0] code_o;

    int checks = 0;
    int errors = 0;

    pvic_top #(.HW_IRQS(NHW)) uut (
        .clk(clk), .rst(rst), .irq_i(irq_i), .rxf_a_i(rxf_a_i), .rxf_b_i(rxf_b_i),
        .swi_i(swi_i), .ipoint_i(ipoint_i), .rti_i(rti_i), .utrap_i(utrap_i),
        .dtrap_i(dtrap_i), .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
        .reg_wdata_i(reg_wdata_i), .status_o(status_o), .enable_o(enable_o),
        .branch_o(branch_o), .vector_o(vector_o), .iack_o(iack_o), .code_o(code_o)
    );

    always #2.5 clk = ~clk;

    // {irq pattern, enable word, branch expected, vector, code}
    localparam int NV = 7;
    localparam logic [21:0] VECS [NV] = '{
        {4'b0001, 5'b11111, 1'b1, 8'h04, 4'd1},
        {4'b1010, 5'b11111, 1'b1, 8'h08, 4'd2},
        {4'b1100, 5'b11111, 1'b1, 8'h0C, 4'd3},
        {4'b1111, 5'b11110, 1'b1, 8'h08, 4'd2},
        {4'b1000, 5'b11111, 1'b1, 8'h10, 4'd4},
        {4'b0110, 5'b11011, 1'b1, 8'h08, 4'd2},
        {4'b0001, 5'b11110, 1'b0, 8'h00, 4'd0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [NS-1:0] d);
        reg_wr_i = 1; reg_sel_i = sel; reg_wdata_i = d;
        tick();
        reg_wr_i = 0; reg_sel_i = 0; reg_wdata_i = '0;
    endtask

    task automatic edge_irq(input logic [NHW-1:0] p);
        irq_i = p; tick(); irq_i = '0; tick();
    endtask

    task automatic strobe_ip();
        ipoint_i = 1; tick(); ipoint_i = 0;
    endtask

    task automatic strobe_rti();
        rti_i = 1; tick(); rti_i = 0;
    endtask

    task automatic take_expect(input string req, input logic [7:0] v, input logic [3:0] c);
        check({req, " branch"}, 32'(branch_o), 1);
        check({req, " vector"}, 32'(vector_o), 32'(v));
        check({req, " code"}, 32'(code_o), 32'(c));
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(); tick();
        // R1 reset state
        check("R1 iack", 32'(iack_o), 0);
        check("R1 code", 32'(code_o), 0);
        check("R1 branch", 32'(branch_o), 0);
        check("R1 status", 32'(status_o), 0);
        check("R1 enable", 32'(enable_o), 0);
        rst = 0; tick();

        // R4 priority and vector table
        for (int k = 0; k < NV; k++) begin
            wr(1'b0, {1'b0, VECS[k][17:13]});
            edge_irq(VECS[k][21:18]);
            strobe_ip();
            if (VECS[k][12]) begin
                take_expect("R4", VECS[k][11:4], VECS[k][3:0]);
                check("R5 iack up", 32'(iack_o), 1);
                strobe_rti();
                check("R5 iack down", 32'(iack_o), 0);
            end else begin
                check("R2 masked no branch", 32'(branch_o), 0);
                check("R2 masked latched", 32'(status_o[0]), 1);
            end
            wr(1'b1, '1);
            check("R7 cleared", 32'(status_o), 0);
        end

        // R2 / R3 masked then unmasked
        wr(1'b0, '0);
        edge_irq(4'b0001);
        strobe_ip();
        check("R2 no take", 32'(branch_o), 0);
        check("R2 pending", 32'(status_o), 32'h01);
        wr(1'b0, 6'h1F);
        strobe_ip();
        take_expect("R3", 8'h04, 4'd1);
        strobe_rti();
        check("R6 status after rti", 32'(status_o), 0);

        // R5 / R6 sequential service
        edge_irq(4'b0101);
        strobe_ip();
        take_expect("R6 first", 8'h04, 4'd1);
        strobe_ip();
        check("R5 blocked", 32'(branch_o), 0);
        check("R5 code held", 32'(code_o), 1);
        strobe_rti();
        check("R6 one bit cleared", 32'(status_o), 32'h04);
        strobe_ip();
        take_expect("R6 second", 8'h0C, 4'd3);
        strobe_rti();

        // R8 wake-up and software interrupt
        rxf_b_i = 1; tick(); rxf_b_i = 0; tick();
        check("R8 wake pending", 32'(status_o), 32'h10);
        strobe_ip();
        take_expect("R8 wake", 8'h14, 4'd5);
        strobe_rti();
        wr(1'b0, '0);
        swi_i = 1; tick(); swi_i = 0;
        strobe_ip();
        take_expect("R8 swi", 8'h18, 4'd6);
        strobe_rti();

        // R7 write-one-to-clear
        edge_irq(4'b0011);
        check("R7 before", 32'(status_o), 32'h03);
        wr(1'b1, 6'h01);
        check("R7 after", 32'(status_o), 32'h02);
        wr(1'b1, '1);
        wr(1'b0, 6'h1F);

        // R9 / R10 / R11 traps over an interrupt in service
        edge_irq(4'b0001);
        strobe_ip();
        take_expect("R9 base irq", 8'h04, 4'd1);
        utrap_i = 1; tick();
        take_expect("R9 utrap", 8'h46, 4'hD);
        tick();
        check("R11 held no refire", 32'(branch_o), 0);
        dtrap_i = 1; tick();
        check("R11 nested ignored", 32'(branch_o), 0);
        strobe_rti();
        check("R9 iack restored", 32'(iack_o), 1);
        check("R9 code restored", 32'(code_o), 1);
        tick();
        check("R11 ignored stays", 32'(branch_o), 0);
        utrap_i = 0; dtrap_i = 0; tick();
        dtrap_i = 1; tick();
        check("R10 dtrap branch", 32'(branch_o), 1);
        check("R10 dtrap vector", 32'(vector_o), 32'h03);
        check("R10 iack kept", 32'(iack_o), 1);
        check("R10 code kept", 32'(code_o), 1);
        dtrap_i = 0;
        strobe_rti();
        check("R10 irq still in service", 32'(code_o), 1);
        strobe_rti();
        check("R5 done", 32'(iack_o), 0);

        // R9 trap beats a same-cycle boundary
        edge_irq(4'b0001);
        utrap_i = 1; ipoint_i = 1; tick(); ipoint_i = 0; utrap_i = 0;
        take_expect("R9 priority", 8'h46, 4'hD);
        strobe_rti();
        check("R9 trap ended", 32'(iack_o), 0);
        strobe_ip();
        take_expect("R9 deferred irq", 8'h04, 4'd1);
        strobe_rti();

        // R11 re-arm only after deassertion
        utrap_i = 1; tick();
        check("R11 first", 32'(branch_o), 1);
        strobe_rti();
        tick();
        check("R11 level held", 32'(branch_o), 0);
        utrap_i = 0; tick();
        utrap_i = 1; tick();
        take_expect("R11 rearmed", 8'h46, 4'hD);
        utrap_i = 0;
        strobe_rti();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule